// File: doc/BRIEF.md
# Latched Interrupt Arbiter

This block chooses which interrupt an 8-bit processor core services next. It watches two groups of port pins, each group feeding one external vector, a set of peripheral flag/enable pairs and a software trap strobe. It presents a single request line and the index of the winning vector to the core. The core reports acceptance with a one-cycle acknowledge, and the block then clears the latch of the accepted source where one exists.

Within a group, the pins whose enable is set are combined by a logical AND. The result goes through one detector whose sensitivity is chosen per vector. Maskable requests that arrive while the core's global mask bit is set stay latched and are presented once the mask drops. The trap ignores the mask. Two wake outputs tell the power controller whether a pending source may end a halt state (external vectors only) or a wait state (any source).

Top module: `irq_latch_arbiter`

## Requirements
- R1: While `imask` is 1, `irq_req` is asserted only for the trap, so `vec_id` is 0 whenever `irq_req` and `imask` are both 1.
- R2: An external or peripheral request that becomes pending while `imask` is 1 stays pending. It raises `irq_req` in the same cycle that `imask` returns to 0.
- R3: A one-cycle `trap_req` is latched at the clock edge where it is sampled. From the next cycle `irq_req` is 1 with `vec_id` 0, whatever the value of `imask`. The latch clears at an edge where `ack` is 1 and `vec_id` is 0.
- R4: Each vector's input is the AND of the pins whose enable bit is 1, and pins whose enable bit is 0 have no effect. If a group has no enabled pin, its input is held low and can never produce an edge. An enabled pin held low therefore hides edges on the other pins of its group.
- R5: Each vector has a 2-bit sensitivity field (`sense_sel[1:0]` for vector 1, `[3:2]` for vector 2) with these codes: 00 latches falling edges, 01 latches rising edges, 10 latches both edges, and 11 latches falling edges and also requests while the input is low. A detected edge becomes visible one cycle after the edge that samples it. Edges are compared only between samples taken after reset.
- R6: The edge latch of an external vector clears at an edge where `ack` is 1 and `vec_id` names that vector. Under code 11 the request stays active while the input remains low.
- R7: Vector indices are 0 for the trap, 1 and 2 for the pin groups, and 3+i for peripheral i. Among the requests eligible under R1, the lowest index is presented, and `vec_id` is 0 when no request is presented.
- R8: Peripheral i requests only while both `per_flag[i]` and `per_en[i]` are 1. Clearing the flag withdraws the request in the same cycle, and `ack` has no effect on it.
- R9: `halt_wake` is 1 exactly when an external vector is pending, independent of `imask`. `wait_wake` is 1 when any source (trap, external, peripheral) is pending.
- R10: During reset and in the first cycle after it, all outputs are 0. The first post-reset sample of a group does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_lvl | input | 2*PINS_PER_VEC | Pin levels, low half is group 1, high half group 2 |
| pin_en | input | 2*PINS_PER_VEC | Per-pin interrupt enable, same layout |
| sense_sel | input | 4 | Sensitivity code per vector (R5) |
| per_flag | input | N_PERIPH | Peripheral event flags |
| per_en | input | N_PERIPH | Peripheral interrupt enables |
| trap_req | input | 1 | Software trap strobe |
| imask | input | 1 | Global interrupt mask bit of the core |
| ack | input | 1 | Core accepts the presented vector |
| irq_req | output | 1 | Interrupt request to the core |
| vec_id | output | VEC_W | Index of the presented vector |
| halt_wake | output | 1 | External source pending |
| wait_wake | output | 1 | Any source pending |

## Verification
The bench holds one enabled pin low and pulses another in rising mode. A detector placed before the AND would raise a request there that the AND must hide. It also toggles disabled pins and empties a group's enable set, where a missing gate would create phantom edges. Requests are stacked under the mask together with a trap. An arbiter with the wrong order, or one that lets the mask block the trap, would present the wrong index after each acknowledge. It checks that the low-level code keeps requesting after acknowledge, that an edge-only code does not, and that clearing a peripheral flag drops a request the core never took.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      SNS_FALL     = 2'b00,
      SNS_RISE     = 2'b01,
      SNS_BOTH     = 2'b10,
      SNS_FALL_LOW = 2'b11
   } sense_e;

   localparam int NUM_EXT     = 2;
   localparam int VEC_TRAP    = 0;
   localparam int VEC_EXT0    = 1;
   localparam int VEC_PERIPH0 = VEC_EXT0 + NUM_EXT;

endpackage

// File: rtl/irq_ext_detect.sv
module irq_ext_detect
   import irq_arb_pkg::*;
#(
   parameter int PINS = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] pin,
   input  logic [PINS-1:0] en,
   input  logic [1:0]      sense,
   input  logic            clr,
   output logic            pend
);

   logic any_en;
   logic comb_now;
   logic comb_q;
   logic en_q;
   logic primed;
   logic edge_lat;
   logic rise;
   logic fall;
   logic hit;
   sense_e mode;

   assign mode     = sense_e'(sense);
   assign any_en   = |en;
   // disabled pins are forced to 1 so they drop out of the AND
   assign comb_now = any_en & (&(pin | ~en));
   assign rise     = primed &  comb_now & ~comb_q;
   assign fall     = primed & ~comb_now &  comb_q;

   always_comb begin
      unique case (mode)
         SNS_FALL:     hit = fall;
         SNS_RISE:     hit = rise;
         SNS_BOTH:     hit = rise | fall;
         SNS_FALL_LOW: hit = fall;
         default:      hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         comb_q   <= 1'b0;
         en_q     <= 1'b0;
         primed   <= 1'b0;
         edge_lat <= 1'b0;
      end else begin
         comb_q   <= comb_now;
         en_q     <= any_en;
         primed   <= 1'b1;
         edge_lat <= (edge_lat & ~clr) | hit;
      end
   end

   assign pend = edge_lat | ((mode == SNS_FALL_LOW) & primed & en_q & ~comb_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int N = 6,
   parameter int W = 3
) (
   input  logic [N-1:0] req,
   output logic         any,
   output logic [W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
   end

   assign any = |req;

endmodule

// File: rtl/irq_latch_arbiter.sv
module irq_latch_arbiter
   import irq_arb_pkg::*;
#(
   parameter int PINS_PER_VEC = 4,
   parameter int N_PERIPH     = 3,
   parameter int NUM_VEC      = VEC_PERIPH0 + N_PERIPH,
   parameter int VEC_W        = $clog2(NUM_VEC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [2*PINS_PER_VEC-1:0] pin_lvl,
   input  logic [2*PINS_PER_VEC-1:0] pin_en,
   input  logic [3:0]                sense_sel,
   input  logic [N_PERIPH-1:0]       per_flag,
   input  logic [N_PERIPH-1:0]       per_en,
   input  logic                      trap_req,
   input  logic                      imask,
   input  logic                      ack,
   output logic                      irq_req,
   output logic [VEC_W-1:0]          vec_id,
   output logic                      halt_wake,
   output logic                      wait_wake
);

   initial begin
      if (PINS_PER_VEC < 1) $error("PINS_PER_VEC must be at least 1");
      if (N_PERIPH < 1) $error("N_PERIPH must be at least 1");
      if (NUM_VEC != VEC_PERIPH0 + N_PERIPH) $error("NUM_VEC must not be overridden");
      if ((1 << VEC_W) < NUM_VEC) $error("VEC_W too narrow for NUM_VEC");
   end

   logic                take;
   logic                trap_pend;
   logic [NUM_EXT-1:0]  ext_pend;
   logic [N_PERIPH-1:0] per_pend;
   logic [NUM_VEC-1:0]  src;
   logic [NUM_VEC-1:0]  elig;

   assign take = ack & irq_req;

   // trap latch: a new strobe wins over a simultaneous clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) trap_pend <= 1'b0;
      else        trap_pend <= (trap_pend & ~(take & (vec_id == VEC_W'(VEC_TRAP)))) | trap_req;
   end

   for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
      irq_ext_detect #(.PINS(PINS_PER_VEC)) u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .pin   (pin_lvl[g*PINS_PER_VEC +: PINS_PER_VEC]),
         .en    (pin_en[g*PINS_PER_VEC +: PINS_PER_VEC]),
         .sense (sense_sel[2*g +: 2]),
         .clr   (take & (vec_id == VEC_W'(VEC_EXT0 + g))),
         .pend  (ext_pend[g])
      );
   end

   // peripheral requests follow flag and enable directly
   for (genvar p = 0; p < N_PERIPH; p++) begin : g_per
      assign per_pend[p] = per_flag[p] & per_en[p];
   end

   assign src  = {per_pend, ext_pend, trap_pend};
   assign elig = src & {{(NUM_VEC-1){~imask}}, 1'b1};

   irq_prio_pick #(.N(NUM_VEC), .W(VEC_W)) u_pick (
      .req (elig),
      .any (irq_req),
      .idx (vec_id)
   );

   assign halt_wake = |ext_pend;
   assign wait_wake = |src;

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
   parameter int N_PERIPH = 3,
   parameter int VEC_W    = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                imask,
   input logic                trap_req,
   input logic [N_PERIPH-1:0] per_flag,
   input logic [N_PERIPH-1:0] per_en,
   input logic                irq_req,
   input logic [VEC_W-1:0]    vec_id,
   input logic                halt_wake,
   input logic                wait_wake
);

   p_mask_trap_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && imask) |-> (vec_id == '0));

   p_trap_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> (irq_req && vec_id == '0));

   p_periph_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && int'(vec_id) >= 3) |->
         (per_flag[int'(vec_id) - 3] && per_en[int'(vec_id) - 3]));

   p_periph_wakes_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((per_flag & per_en) != '0) |-> wait_wake);

   p_halt_implies_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_wake |-> wait_wake);

   p_req_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> wait_wake);

   p_idle_vec_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (vec_id == '0));

endmodule

bind irq_latch_arbiter irq_arb_chk #(.N_PERIPH(N_PERIPH), .VEC_W(VEC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .imask     (imask),
   .trap_req  (trap_req),
   .per_flag  (per_flag),
   .per_en    (per_en),
   .irq_req   (irq_req),
   .vec_id    (vec_id),
   .halt_wake (halt_wake),
   .wait_wake (wait_wake)
);

// File: tb/sim_irq_latch_arbiter.sv
module sim_irq_latch_arbiter;

   localparam int P  = 4;
   localparam int NP = 3;
   localparam int VW = 3;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [2*P-1:0]  pin_lvl;
   logic [2*P-1:0]  pin_en;
   logic [3:0]      sense_sel;
   logic [NP-1:0]   per_flag;
   logic [NP-1:0]   per_en;
   logic            trap_req;
   logic            imask;
   logic            ack;
   logic            irq_req;
   logic [VW-1:0]   vec_id;
   logic            halt_wake;
   logic            wait_wake;

   always #2 clk = ~clk;

   irq_latch_arbiter #(.PINS_PER_VEC(P), .N_PERIPH(NP)) u0 (
      .clk, .rst_n, .pin_lvl, .pin_en, .sense_sel, .per_flag, .per_en,
      .trap_req, .imask, .ack, .irq_req, .vec_id, .halt_wake, .wait_wake
   );

   typedef struct packed {
      logic          req;
      logic [VW-1:0] vec;
      logic          hw;
      logic          ww;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_run  = 0;
   int    n_fail = 0;
   bit    done   = 0;

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic expect_out(input logic req, input int vec, input logic hw,
                             input logic ww, input string tag);
      exp_t e;
      e.req = req; e.vec = VW'(vec); e.hw = hw; e.ww = ww;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      #0;
   endtask

   // monitor: compares outputs as soon as an expectation is queued
   initial begin
      forever begin
         exp_t  e;
         exp_t  a;
         string t;
         wait (exp_q.size() != 0);
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         a = {irq_req, vec_id, halt_wake, wait_wake};
         n_run++;
         if (a !== e) begin
            n_fail++;
            $display("FAIL %s: got req=%b vec=%0d hw=%b ww=%b, expected req=%b vec=%0d hw=%b ww=%b",
                     t, a.req, a.vec, a.hw, a.ww, e.req, e.vec, e.hw, e.ww);
         end
      end
   end

   task automatic do_ack();
      ack = 1'b1;
      tick();
      ack = 1'b0;
   endtask

   initial begin
      #80000;
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; pin_lvl = '1; pin_en = 8'b0011_1111;
      sense_sel = 4'b0101; per_flag = '0; per_en = '0;
      trap_req = 1'b0; imask = 1'b0; ack = 1'b0;
      repeat (3) tick();
      expect_out(0, 0, 0, 0, "R10 outputs in reset");
      rst_n = 1'b1;
      tick();
      expect_out(0, 0, 0, 0, "R10 first sample not an edge");
      tick();
      expect_out(0, 0, 0, 0, "R10 idle after reset");

      // falling edge on group 1
      sense_sel[1:0] = 2'b00;
      pin_lvl[2] = 1'b0; tick();
      expect_out(1, 1, 1, 1, "R5 falling edge latched");
      tick();
      expect_out(1, 1, 1, 1, "R5 edge latch holds");
      do_ack();
      expect_out(0, 0, 0, 0, "R6 ack clears edge latch");
      pin_lvl[2] = 1'b1; tick();
      expect_out(0, 0, 0, 0, "R5 rising ignored under code 00");

      // AND masking under rising sensitivity
      sense_sel[1:0] = 2'b01;
      pin_lvl[1] = 1'b0; tick();
      expect_out(0, 0, 0, 0, "R5 falling ignored under code 01");
      pin_lvl[3] = 1'b0; tick();
      pin_lvl[3] = 1'b1; tick();
      expect_out(0, 0, 0, 0, "R4 low enabled pin hides rising edge");
      pin_lvl[1] = 1'b1; tick();
      expect_out(1, 1, 1, 1, "R4 rise once all enabled pins high");
      do_ack();
      expect_out(0, 0, 0, 0, "R6 clear group 1");

      // disabled pins in group 2 (bits 7:6 disabled)
      pin_lvl[7] = 1'b0; tick();
      pin_lvl[7] = 1'b1; tick();
      expect_out(0, 0, 0, 0, "R4 disabled pin ignored");
      pin_lvl[4] = 1'b0; tick();
      pin_lvl[4] = 1'b1; tick();
      expect_out(1, 2, 1, 1, "R5 rising edge on group 2");
      do_ack();
      expect_out(0, 0, 0, 0, "R6 clear group 2");

      // masked request held pending
      imask = 1'b1;
      pin_lvl[4] = 1'b0; tick();
      pin_lvl[4] = 1'b1; tick();
      expect_out(0, 0, 1, 1, "R1 masked request withheld, R9 wakes");
      imask = 1'b0; tick();
      expect_out(1, 2, 1, 1, "R2 pending request issued after unmask");
      do_ack();

      // priority stack
      imask = 1'b1;
      pin_lvl[4] = 1'b0; tick();
      pin_lvl[4] = 1'b1; tick();
      pin_lvl[0] = 1'b0; tick();
      pin_lvl[0] = 1'b1; tick();
      per_en = 3'b111; per_flag = 3'b001;
      trap_req = 1'b1; tick();
      trap_req = 1'b0;
      expect_out(1, 0, 1, 1, "R3 trap taken while masked");
      do_ack();
      expect_out(0, 0, 1, 1, "R3 trap cleared by ack, R1 others masked");
      imask = 1'b0; tick();
      expect_out(1, 1, 1, 1, "R7 group 1 before group 2");
      do_ack();
      expect_out(1, 2, 1, 1, "R7 group 2 before peripheral");
      do_ack();
      expect_out(1, 3, 0, 1, "R7 peripheral 0 last, R9 no halt wake");
      do_ack();
      expect_out(1, 3, 0, 1, "R8 ack does not clear peripheral");
      per_flag = 3'b000; tick();
      expect_out(0, 0, 0, 0, "R8 cleared flag withdraws request");

      // peripheral enable gating and order
      per_flag = 3'b100; per_en = 3'b011; tick();
      expect_out(0, 0, 0, 0, "R8 flag without enable ignored");
      per_en = 3'b111; tick();
      expect_out(1, 5, 0, 1, "R8 flag with enable requests");
      per_flag = 3'b110; tick();
      expect_out(1, 4, 0, 1, "R7 lower peripheral index wins");
      per_flag = 3'b000; tick();

      // falling edge plus low level
      sense_sel[1:0] = 2'b11;
      pin_lvl[2] = 1'b0; tick();
      expect_out(1, 1, 1, 1, "R5 code 11 falling edge");
      do_ack();
      expect_out(1, 1, 1, 1, "R6 level persists after ack");
      pin_lvl[2] = 1'b1; tick();
      expect_out(0, 0, 0, 0, "R5 level request ends when high");

      // both edges
      sense_sel[1:0] = 2'b10;
      pin_lvl[2] = 1'b0; tick();
      expect_out(1, 1, 1, 1, "R5 code 10 falling");
      do_ack();
      expect_out(0, 0, 0, 0, "R6 code 10 clear");
      pin_lvl[2] = 1'b1; tick();
      expect_out(1, 1, 1, 1, "R5 code 10 rising");
      do_ack();

      // empty enable set
      sense_sel[1:0] = 2'b01;
      pin_en[3:0] = 4'b0000; tick();
      pin_lvl[0] = 1'b0; tick();
      pin_lvl[0] = 1'b1; tick();
      expect_out(0, 0, 0, 0, "R4 group without enables silent");

      // trap alone
      trap_req = 1'b1; tick();
      trap_req = 1'b0;
      expect_out(1, 0, 0, 1, "R3 trap alone, R9 no halt wake");
      do_ack();
      expect_out(0, 0, 0, 0, "R3 trap cleared");

      tick();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule